// File: doc/BRIEF.md
# Transaction ID Compaction Table

This block maps transaction IDs from a wide, sparsely used ID space onto a small, dense index space. It also counts how many transactions are outstanding for each mapped ID. A requester presents a wide ID. In the same cycle the block returns a narrow index, which is either the index that ID already holds or a newly allocated free entry. A completer presents a narrow index. In the same cycle the block returns the wide ID stored at that entry and decrements the entry's count.

The mapping is one-to-one. Two different wide IDs never share an index, and a wide ID keeps its index for as long as it has transactions in flight. A request is refused through a stall output in two cases: the ID is new and no entry is free, or the ID has already reached its per-ID outstanding limit. A system with separate read and write paths uses one instance for each. An operation that counts as both a read and a write allocates and releases in both instances in the same cycle.

Top module: `idmap_table`

## Requirements
- R1: After reset every entry is free, so the first request of any wide ID is accepted without stall and receives index 0.
- R2: A request whose wide ID is already held by an occupied entry receives that entry's index.
- R3: Occupied entries always hold pairwise distinct wide IDs, so distinct in-flight wide IDs get distinct indices.
- R4: A request whose wide ID matches no occupied entry is given the lowest-numbered free entry.
- R5: A request whose wide ID is new while all MAX_UNIQ entries are occupied is stalled in the same cycle.
- R6: A request whose ID entry already counts MAX_TXN outstanding transactions is stalled; a count never exceeds MAX_TXN.
- R7: A completion on index k returns, in the same cycle, the wide ID stored in entry k and lowers that entry's count by one.
- R8: An entry whose count reaches zero is free from the next cycle, and a new wide ID may be allocated to it then.
- R9: An accepted request and a completion on the same entry in the same cycle leave that entry's count unchanged.
- R10: The narrow index is the entry number zero-extended to NARROW_W bits; bits above the entry-number width are 0.
- R11: A stalled request changes no entry: neither a count nor a stored wide ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; frees every entry |
| req_valid | input | 1 | A request with wide ID req_id is presented |
| req_id | input | WIDE_W | Wide transaction ID of the request |
| req_stall | output | 1 | Request refused this cycle (table full or ID at its limit) |
| req_idx | output | NARROW_W | Narrow index given to the request; valid when not stalled |
| cpl_valid | input | 1 | A completion for index cpl_idx is presented |
| cpl_idx | input | NARROW_W | Narrow index of the completing transaction |
| cpl_id | output | WIDE_W | Wide ID stored at entry cpl_idx |

## Verification
req_stall, req_idx and cpl_id are combinational functions of the registered table and the current inputs. The bench therefore drives inputs just after a falling edge and samples these outputs 1 ns later, before the next rising edge. Count changes made at that rising edge appear only in the next cycle's responses. Frees, reuse after release and the same-cycle allocate-plus-complete case are therefore checked one request later, where they show up as an index or a stall. A reference model of counts and stored IDs is updated at each rising edge. A directed sweep checks literal expected values, and a few thousand random request and completion cycles over six wide IDs repeatedly fill the four entries.

// File: rtl/idmap_pkg.sv
package idmap_pkg;
  // Entry-number width; at least one bit even for a single-entry table.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/idmap_entry.sv
module idmap_entry #(
  parameter int unsigned WIDE_W  = 8,
  parameter int unsigned MAX_TXN = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  input  logic [WIDE_W-1:0] id_in,
  output logic              busy,
  output logic              at_limit,
  output logic [WIDE_W-1:0] id_q,
  output logic [CNT_W-1:0]  cnt_q
);
  // Outstanding count; zero means the entry is free.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // Stored wide ID: written only when a free entry is claimed, no reset.
  always_ff @(posedge clk) begin
    if (inc && (cnt_q == '0)) begin
      id_q <= id_in;
    end
  end

  assign busy     = (cnt_q != '0);
  assign at_limit = (cnt_q == CNT_W'(MAX_TXN));
endmodule

// File: rtl/idmap_lookup.sv
module idmap_lookup #(
  parameter int unsigned N      = 4,
  parameter int unsigned WIDE_W = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [WIDE_W-1:0]         key,
  input  logic [N-1:0]              busy,
  input  logic [N-1:0][WIDE_W-1:0]  ids,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx,
  output logic                      free_any,
  output logic [IDX_W-1:0]          free_idx
);
  // Parallel compare against occupied entries; at most one can match.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (busy[i] && (ids[i] == key) && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // Lowest-numbered free entry: scan downward so the lowest wins.
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/idmap_table.sv
module idmap_table #(
  parameter int unsigned WIDE_W   = 8,
  parameter int unsigned MAX_UNIQ = 4,
  parameter int unsigned MAX_TXN  = 4,
  parameter int unsigned NARROW_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [WIDE_W-1:0]   req_id,
  output logic                req_stall,
  output logic [NARROW_W-1:0] req_idx,
  input  logic                cpl_valid,
  input  logic [NARROW_W-1:0] cpl_idx,
  output logic [WIDE_W-1:0]   cpl_id
);
  localparam int unsigned IDX_W = idmap_pkg::idx_bits(MAX_UNIQ);
  localparam int unsigned CNT_W = $clog2(MAX_TXN + 1);

  logic [MAX_UNIQ-1:0]             busy_v;
  logic [MAX_UNIQ-1:0]             lim_v;
  logic [MAX_UNIQ-1:0]             inc_v;
  logic [MAX_UNIQ-1:0]             dec_v;
  logic [MAX_UNIQ-1:0][WIDE_W-1:0] id_all;
  logic [MAX_UNIQ-1:0][CNT_W-1:0]  cnt_all;

  logic             hit, free_any, accept;
  logic [IDX_W-1:0] hit_idx, free_idx, sel_idx;

  idmap_lookup #(
    .N(MAX_UNIQ), .WIDE_W(WIDE_W), .IDX_W(IDX_W)
  ) u_lookup (
    .key(req_id), .busy(busy_v), .ids(id_all),
    .hit(hit), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx)
  );

  assign sel_idx   = hit ? hit_idx : free_idx;
  assign req_stall = req_valid && (hit ? lim_v[hit_idx] : !free_any);
  assign accept    = req_valid && !req_stall;
  assign req_idx   = NARROW_W'(sel_idx);

  for (genvar g = 0; g < int'(MAX_UNIQ); g++) begin : g_ent
    assign inc_v[g] = accept && (sel_idx == IDX_W'(g));
    assign dec_v[g] = cpl_valid && (cpl_idx == NARROW_W'(g));

    idmap_entry #(
      .WIDE_W(WIDE_W), .MAX_TXN(MAX_TXN), .CNT_W(CNT_W)
    ) u_entry (
      .clk(clk), .rst(rst),
      .inc(inc_v[g]), .dec(dec_v[g]), .id_in(req_id),
      .busy(busy_v[g]), .at_limit(lim_v[g]),
      .id_q(id_all[g]), .cnt_q(cnt_all[g])
    );
  end

  // Completion read-back: select the stored ID of the addressed entry.
  always_comb begin
    cpl_id = '0;
    for (int i = 0; i < int'(MAX_UNIQ); i++) begin
      if (cpl_idx == NARROW_W'(i)) cpl_id = id_all[i];
    end
  end
endmodule

// File: rtl/idmap_table_chk.sv
module idmap_table_chk #(
  parameter int unsigned WIDE_W   = 8,
  parameter int unsigned MAX_UNIQ = 4,
  parameter int unsigned MAX_TXN  = 4,
  parameter int unsigned NARROW_W = 3,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned CNT_W    = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            req_valid,
  input logic [WIDE_W-1:0]               req_id,
  input logic                            req_stall,
  input logic [NARROW_W-1:0]             req_idx,
  input logic                            cpl_valid,
  input logic [NARROW_W-1:0]             cpl_idx,
  input logic [MAX_UNIQ-1:0]             busy,
  input logic [MAX_UNIQ-1:0]             inc,
  input logic [MAX_UNIQ-1:0]             dec,
  input logic [MAX_UNIQ-1:0][WIDE_W-1:0] id_all,
  input logic [MAX_UNIQ-1:0][CNT_W-1:0]  cnt_all
);
  logic any_match;
  always_comb begin
    any_match = 1'b0;
    for (int i = 0; i < int'(MAX_UNIQ); i++) begin
      if (busy[i] && (id_all[i] == req_id)) any_match = 1'b1;
    end
  end

  initial begin
    a_r10_width_ok : assert (NARROW_W >= IDX_W);
  end

  // R5: new ID with a full table must stall
  a_r5_full_stall : assert property (@(posedge clk) disable iff (rst)
    (req_valid && (&busy) && !any_match) |-> req_stall);

  // R7: completions only address occupied entries
  a_r7_cpl_range : assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> (cpl_idx < NARROW_W'(MAX_UNIQ)));

  if (NARROW_W > IDX_W) begin : g_hi
    // R10: upper index bits stay zero
    a_r10_upper_zero : assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_stall) |-> (req_idx[NARROW_W-1:IDX_W] == '0));
  end

  for (genvar i = 0; i < int'(MAX_UNIQ); i++) begin : g_e
    // R7: a completion on a free entry is illegal
    a_r7_cpl_busy : assert property (@(posedge clk) disable iff (rst)
      (cpl_valid && (cpl_idx == NARROW_W'(i))) |-> busy[i]);
    // R6: count never exceeds the per-ID limit
    a_r6_cnt_bound : assert property (@(posedge clk) disable iff (rst)
      cnt_all[i] <= CNT_W'(MAX_TXN));
    // R9: allocate plus complete on one entry keeps its count
    a_r9_same_cycle : assert property (@(posedge clk) disable iff (rst)
      (inc[i] && dec[i]) |=> $stable(cnt_all[i]));
    // R8: the last completion frees the entry
    a_r8_free_last : assert property (@(posedge clk) disable iff (rst)
      ((cnt_all[i] == CNT_W'(1)) && dec[i] && !inc[i]) |=> !busy[i]);
    for (genvar j = i + 1; j < int'(MAX_UNIQ); j++) begin : g_p
      // R3: occupied entries hold distinct wide IDs
      a_r3_one_to_one : assert property (@(posedge clk) disable iff (rst)
        (busy[i] && busy[j]) |-> (id_all[i] != id_all[j]));
    end
  end
endmodule

bind idmap_table idmap_table_chk #(
  .WIDE_W(WIDE_W), .MAX_UNIQ(MAX_UNIQ), .MAX_TXN(MAX_TXN),
  .NARROW_W(NARROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
  .req_stall(req_stall), .req_idx(req_idx), .cpl_valid(cpl_valid),
  .cpl_idx(cpl_idx), .busy(busy_v), .inc(inc_v), .dec(dec_v),
  .id_all(id_all), .cnt_all(cnt_all)
);

// File: tb/test_idmap_table.sv
`timescale 1ns/1ps
module test_idmap_table;
  localparam int WW = 4, NU = 4, MT = 2, NW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [WW-1:0] req_id = '0;
  logic          req_stall;
  logic [NW-1:0] req_idx;
  logic          cpl_valid = 1'b0;
  logic [NW-1:0] cpl_idx = '0;
  logic [WW-1:0] cpl_id;

  always #2 clk = ~clk;

  idmap_table #(.WIDE_W(WW), .MAX_UNIQ(NU), .MAX_TXN(MT), .NARROW_W(NW)) i_idmap_table (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
    .req_stall(req_stall), .req_idx(req_idx),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_id(cpl_id)
  );

  int tests = 0, fails = 0;
  int m_cnt [NU];
  logic [WW-1:0] m_id [NU];
  int last_stall, last_idx, last_cpl;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit rv, input int rid, input bit cv, input int cidx,
                      input string tag);
    int hidx, fidx, e_idx;
    bit e_stall;
    @(negedge clk);
    req_valid = rv; req_id = WW'(rid); cpl_valid = cv; cpl_idx = NW'(cidx);
    #1;
    hidx = -1; fidx = -1;
    for (int i = 0; i < NU; i++)
      if (m_cnt[i] != 0 && m_id[i] == WW'(rid)) hidx = i;
    for (int i = NU - 1; i >= 0; i--)
      if (m_cnt[i] == 0) fidx = i;
    e_stall = (hidx >= 0) ? (m_cnt[hidx] == MT) : (fidx < 0);
    e_idx   = (hidx >= 0) ? hidx : fidx;
    last_stall = int'(req_stall); last_idx = int'(req_idx); last_cpl = int'(cpl_id);
    if (rv) begin
      check(tag, int'(req_stall), int'(e_stall));
      if (!e_stall) begin
        check(tag, int'(req_idx), e_idx);
        check("R10", int'(req_idx[NW-1]), 0);
      end
    end
    if (cv) check("R7", int'(cpl_id), int'(m_id[cidx]));
    @(posedge clk);
    if (rv && !e_stall) begin
      if (m_cnt[e_idx] == 0) m_id[e_idx] = WW'(rid);
      m_cnt[e_idx]++;
    end
    if (cv) m_cnt[cidx]--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NU; i++) begin m_cnt[i] = 0; m_id[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    step(1, 9, 0, 0, "R1"); check("R1", last_stall, 0); check("R1", last_idx, 0);
    step(1, 9, 0, 0, "R2"); check("R2", last_idx, 0);
    step(1, 9, 0, 0, "R6"); check("R6", last_stall, 1);
    step(1, 3, 0, 0, "R4"); check("R4", last_idx, 1);
    step(1, 5, 0, 0, "R3"); check("R3", last_idx, 2);
    step(1, 7, 0, 0, "R3"); check("R3", last_idx, 3);
    step(1, 1, 0, 0, "R5"); check("R5", last_stall, 1);
    step(1, 1, 0, 0, "R11"); check("R11", last_stall, 1);
    step(1, 3, 0, 0, "R11"); check("R11", last_idx, 1);
    step(0, 0, 1, 1, "R7"); check("R7", last_cpl, 3);
    step(0, 0, 1, 1, "R7"); check("R7", last_cpl, 3);
    step(1, 1, 0, 0, "R8"); check("R8", last_idx, 1);
    step(1, 1, 1, 1, "R9"); check("R9", last_idx, 1); check("R9", last_cpl, 1);
    step(1, 1, 0, 0, "R9"); check("R9", last_stall, 0); check("R9", last_idx, 1);
    step(1, 1, 0, 0, "R9"); check("R9", last_stall, 1);
    step(0, 0, 1, 0, "R7"); step(0, 0, 1, 0, "R7");
    step(0, 0, 1, 1, "R7"); step(0, 0, 1, 1, "R7");
    step(0, 0, 1, 2, "R7"); step(0, 0, 1, 3, "R7");
    step(1, 12, 0, 0, "R8"); check("R8", last_idx, 0);
    step(0, 0, 1, 0, "R7"); check("R7", last_cpl, 12);

    for (int n = 0; n < 4000; n++) begin
      bit rv, cv;
      int ci, nb;
      rv = ($urandom % 4) != 0;
      nb = 0;
      for (int i = 0; i < NU; i++) if (m_cnt[i] != 0) nb++;
      cv = (nb != 0) && (($urandom % 3) != 0);
      ci = 0;
      if (cv) begin
        int k;
        k = int'($urandom % nb);
        for (int i = 0; i < NU; i++)
          if (m_cnt[i] != 0) begin
            if (k == 0) ci = i;
            k--;
          end
      end
      step(rv, int'($urandom % 6), cv, ci, "R4");
    end
    @(negedge clk); req_valid = 1'b0; cpl_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule